// File: doc/BRIEF.md
# UART Extended Register Access Unit

This block decodes the host accesses of a 16550-style UART that fall outside the data path and returns their read data. The host bus has a 3-bit address, read and write strobes, and 8-bit write and read data. The block stores the line control byte, the divisor bytes, a scratch byte, a feature control byte, an enhanced mode byte and two FIFO trigger thresholds. The FIFO side supplies the receive and transmit occupancy counts. It also supplies per-character error flags at two moments: when a character is pushed into the receive FIFO, and when a character is loaded into the receive holding position.

Reads are remapped by mode. With the scratch swap enabled, the scratch address returns a FIFO level, selected as receive, transmit or alternating. A dedicated FIFO count and the trigger thresholds can be reached only while the line control byte holds the key value 0xBF. An identity byte and a revision byte take the place of the divisor bytes while the whole divisor is zero. A line-status interrupt request is raised either when an errored character is pushed, or only when it reaches the holding position. It clears when the line status is read.

Top module: `uart_xreg_unit`

## Requirements
- R1: After synchronous reset, every stored byte is 0x00 except the enhanced mode byte, which is 0x80. `irq_line` is low, `rdata` is 0x00, and `divisor`, `rx_thresh`, `tx_thresh` and `flow_hyst` are all 0.
- R2: Address 3 reads and writes the line control byte in every mode. While that byte equals 0xBF (the extended set), address 2 is the feature control byte, address 4 is the trigger/count register and address 7 is the enhanced mode byte. Outside the extended set, addresses 2 and 4 read 0x00. Address 6 reads 0x00, and addresses 0 and 1 read 0x00 while line control bit 7 is clear.
- R3: Outside the extended set, a write to address 7 always stores the scratch byte. A read returns the scratch byte when feature control bit 6 is 0, and the FIFO level when it is 1.
- R4: The FIFO level is selected by enhanced mode bits [1:0]. 00 and 11 give the receive count and 01 gives the transmit count. 10 alternates, starting with receive, and each level read moves to the other count. Writing the enhanced mode byte restarts the alternation at receive.
- R5: In the extended set, a read of address 4 returns the receive count when feature control bit 7 is 0 and the transmit count when it is 1. Counts are zero-extended to 8 bits.
- R6: In the extended set, a write to address 4 loads `rx_thresh` when feature control bit 7 is 0 and `tx_thresh` when it is 1. The thresholds cannot be read back on the bus.
- R7: While line control bit 7 is set, writes to addresses 0 and 1 load the low and high divisor bytes. Reads of addresses 0 and 1 return 0x0A and 0x01 when both bytes are 0x00, and return the divisor bytes otherwise.
- R8: `rdata` is registered. It takes the addressed value on the clock edge that samples `rd` and holds its value in cycles without `rd`.
- R9: With enhanced mode bit 6 set (immediate), `irq_line` rises one cycle after `rx_push` with any bit of `rx_push_err` set. `hold_load` has no effect in this mode.
- R10: With enhanced mode bit 6 clear (delayed), `irq_line` rises one cycle after `hold_load` with any bit of `hold_err` set. `rx_push` has no effect in this mode.
- R11: A read of address 5 returns `hold_err` in bits 4:2 (parity in bit 2, framing in bit 3, break in bit 4) with the other bits 0, and clears `irq_line`. A set event in the same cycle wins over the clear.
- R12: `flow_hyst` follows feature control bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rx_count | input | CW | Receive FIFO occupancy |
| tx_count | input | CW | Transmit FIFO occupancy |
| rx_push | input | 1 | A character is written into the receive FIFO |
| rx_push_err | input | 3 | Error flags of the pushed character {break, framing, parity} |
| hold_load | input | 1 | A character enters the receive holding position |
| hold_err | input | 3 | Error flags of the holding character {break, framing, parity} |
| irq_line | output | 1 | Line-status interrupt request |
| divisor | output | 16 | Divisor {high, low} |
| rx_thresh | output | 8 | Receive trigger threshold |
| tx_thresh | output | 8 | Transmit trigger threshold |
| flow_hyst | output | 2 | Flow-control hysteresis select |

## Verification
The hardest state to reach from the ports is a read of a remapped address under one particular combination of the swap bit, the count-select bit, the extended-set key and a zero or nonzero divisor. Each combination takes a fixed write sequence: unlock with 0xBF, program feature control and enhanced mode, then optionally relock with a non-key line control value. The stimulus walks all sixteen combinations with changing FIFO counts and reads every address after each one. Divisors are chosen so that only the high byte is nonzero in some passes. The alternating level mode is driven through several consecutive reads and a mid-sequence rewrite. Both interrupt modes are driven with events aimed at the opposite mode, and with a status read that lands in the same cycle as a new error.

// File: rtl/uart_xreg_pkg.sv
package uart_xreg_pkg;

    localparam logic [7:0] EXT_KEY   = 8'hBF;
    localparam logic [7:0] ID_CODE   = 8'h0A;
    localparam logic [7:0] REV_CODE  = 8'h01;
    localparam logic [7:0] ENH_RESET = 8'h80;

    typedef enum logic [2:0] {
        AD_DATA  = 3'd0,
        AD_IEN   = 3'd1,
        AD_FEAT  = 3'd2,
        AD_LINE  = 3'd3,
        AD_TRIG  = 3'd4,
        AD_STAT  = 3'd5,
        AD_MSTAT = 3'd6,
        AD_SCR   = 3'd7
    } xaddr_e;

    typedef struct packed {
        logic [7:0] line_ctl;
        logic [7:0] feat_ctl;
        logic [7:0] enh_mode;
        logic [7:0] scratch;
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic [7:0] rx_thresh;
        logic [7:0] tx_thresh;
    } xreg_t;

    localparam xreg_t XREG_RESET = '{
        line_ctl: 8'h00, feat_ctl: 8'h00, enh_mode: ENH_RESET, scratch: 8'h00,
        div_lo: 8'h00, div_hi: 8'h00, rx_thresh: 8'h00, tx_thresh: 8'h00
    };

    function automatic logic in_ext(input logic [7:0] line_ctl);
        return line_ctl == EXT_KEY;
    endfunction

    // 1 selects the transmit count for a level read
    function automatic logic level_is_tx(input logic [1:0] sel, input logic alt);
        case (sel)
            2'b01:   return 1'b1;
            2'b10:   return alt;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_xreg_bank.sv
module uart_xreg_bank
    import uart_xreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr,
    input  logic       wr,
    input  logic [7:0] wdata,
    output xreg_t      regs
);

    logic ext, dlab;
    assign ext  = in_ext(regs.line_ctl);
    assign dlab = regs.line_ctl[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= XREG_RESET;
        end else if (wr) begin
            case (xaddr_e'(addr))
                AD_LINE: regs.line_ctl <= wdata;
                AD_DATA: if (dlab) regs.div_lo <= wdata;
                AD_IEN:  if (dlab) regs.div_hi <= wdata;
                AD_FEAT: if (ext) regs.feat_ctl <= wdata;
                AD_TRIG: if (ext) begin
                    if (regs.feat_ctl[7]) regs.tx_thresh <= wdata;
                    else                  regs.rx_thresh <= wdata;
                end
                AD_SCR:  if (ext) regs.enh_mode <= wdata;
                         else     regs.scratch  <= wdata;
                default: ;
            endcase
        end
    end

    // R6: threshold write steered by feature control bit 7
    a_r6_rx_thresh_load: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd4 && ext && !regs.feat_ctl[7]) |=> regs.rx_thresh == $past(wdata));

    // R3: scratch writes land regardless of the swap bit
    a_r3_scratch_write: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd7 && !ext) |=> regs.scratch == $past(wdata));

endmodule

// File: rtl/uart_xreg_rdmux.sv
module uart_xreg_rdmux
    import uart_xreg_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    addr,
    input  logic          rd,
    input  logic          enh_wr,
    input  logic [7:0]    line_ctl,
    input  logic [7:0]    feat_ctl,
    input  logic [7:0]    enh_mode,
    input  logic [7:0]    scratch,
    input  logic [7:0]    div_lo,
    input  logic [7:0]    div_hi,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic [2:0]    hold_err,
    output logic [7:0]    rdata
);

    logic       ext, dlab, div_zero, alt, level_rd;
    logic [7:0] rx8, tx8, level, rval;

    assign ext      = in_ext(line_ctl);
    assign dlab     = line_ctl[7];
    assign div_zero = (div_lo == 8'h00) && (div_hi == 8'h00);
    assign rx8      = 8'(rx_count);
    assign tx8      = 8'(tx_count);
    assign level    = level_is_tx(enh_mode[1:0], alt) ? tx8 : rx8;
    assign level_rd = rd && addr == 3'd7 && !ext && feat_ctl[6];

    always_comb begin
        rval = 8'h00;
        case (xaddr_e'(addr))
            AD_DATA: if (dlab) rval = div_zero ? ID_CODE  : div_lo;
            AD_IEN:  if (dlab) rval = div_zero ? REV_CODE : div_hi;
            AD_FEAT: if (ext)  rval = feat_ctl;
            AD_LINE: rval = line_ctl;
            AD_TRIG: if (ext)  rval = feat_ctl[7] ? tx8 : rx8;
            AD_STAT: rval = {3'b000, hold_err, 2'b00};
            AD_SCR:  rval = ext ? enh_mode : (feat_ctl[6] ? level : scratch);
            default: rval = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= 8'h00;
            alt   <= 1'b0;
        end else begin
            if (rd) rdata <= rval;
            if (enh_wr) alt <= 1'b0;
            else if (level_rd && enh_mode[1:0] == 2'b10) alt <= ~alt;
        end
    end

    // R8: read data holds between reads
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    // R7: identity byte replaces a zero divisor
    a_r7_id_on_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 3'd0 && dlab && div_lo == 8'h00 && div_hi == 8'h00) |=> rdata == 8'h0A);

endmodule

// File: rtl/uart_xreg_irq.sv
module uart_xreg_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       immediate,
    input  logic       rx_push,
    input  logic [2:0] rx_push_err,
    input  logic       hold_load,
    input  logic [2:0] hold_err,
    input  logic       stat_rd,
    output logic       irq_line
);

    logic set_ev;
    assign set_ev = immediate ? (rx_push && |rx_push_err) : (hold_load && |hold_err);

    always_ff @(posedge clk) begin
        if (rst)          irq_line <= 1'b0;
        else if (set_ev)  irq_line <= 1'b1;
        else if (stat_rd) irq_line <= 1'b0;
    end

    // R9: immediate mode reacts to the push
    a_r9_immediate: assert property (@(posedge clk) disable iff (rst)
        (immediate && rx_push && |rx_push_err) |=> irq_line);

    // R10: delayed mode ignores anything but an errored holding load
    a_r10_delayed_quiet: assert property (@(posedge clk) disable iff (rst)
        (!irq_line && !immediate && !(hold_load && |hold_err)) |=> !irq_line);

    // R11: status read clears when no new event arrives
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !rx_push && !hold_load) |=> !irq_line);

endmodule

// File: rtl/uart_xreg_unit.sv
module uart_xreg_unit
    import uart_xreg_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_push,
    input  logic [2:0]    rx_push_err,
    input  logic          hold_load,
    input  logic [2:0]    hold_err,
    output logic          irq_line,
    output logic [15:0]   divisor,
    output logic [7:0]    rx_thresh,
    output logic [7:0]    tx_thresh,
    output logic [1:0]    flow_hyst
);

    xreg_t regs;
    logic  enh_wr, stat_rd;

    assign enh_wr  = wr && addr == 3'd7 && in_ext(regs.line_ctl);
    assign stat_rd = rd && addr == 3'd5;

    uart_xreg_bank u_bank (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .wdata(wdata), .regs(regs)
    );

    uart_xreg_rdmux #(.CW(CW)) u_rdmux (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .enh_wr(enh_wr),
        .line_ctl(regs.line_ctl), .feat_ctl(regs.feat_ctl), .enh_mode(regs.enh_mode),
        .scratch(regs.scratch), .div_lo(regs.div_lo), .div_hi(regs.div_hi),
        .rx_count(rx_count), .tx_count(tx_count), .hold_err(hold_err), .rdata(rdata)
    );

    uart_xreg_irq u_irq (
        .clk(clk), .rst(rst), .immediate(regs.enh_mode[6]),
        .rx_push(rx_push), .rx_push_err(rx_push_err),
        .hold_load(hold_load), .hold_err(hold_err),
        .stat_rd(stat_rd), .irq_line(irq_line)
    );

    assign divisor   = {regs.div_hi, regs.div_lo};
    assign rx_thresh = regs.rx_thresh;
    assign tx_thresh = regs.tx_thresh;
    assign flow_hyst = regs.feat_ctl[1:0];

    // R12: hysteresis output tracks a feature control write
    a_r12_hyst: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd2 && in_ext(regs.line_ctl)) |=> flow_hyst == $past(wdata[1:0]));

endmodule

// File: tb/sim_uart_xreg_unit.sv
`timescale 1ns/1ps
module sim_uart_xreg_unit;

    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    addr = '0;
    logic          rd = 1'b0, wr = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [CW-1:0] rx_count = '0, tx_count = '0;
    logic          rx_push = 1'b0, hold_load = 1'b0;
    logic [2:0]    rx_push_err = '0, hold_err = '0;
    logic          irq_line;
    logic [15:0]   divisor;
    logic [7:0]    rx_thresh, tx_thresh;
    logic [1:0]    flow_hyst;

    uart_xreg_unit #(.FIFO_DEPTH(64)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata),
        .rx_count(rx_count), .tx_count(tx_count), .rx_push(rx_push), .rx_push_err(rx_push_err),
        .hold_load(hold_load), .hold_err(hold_err), .irq_line(irq_line), .divisor(divisor),
        .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .flow_hyst(flow_hyst)
    );

    always #2.5 clk = ~clk;

    int    n_chk = 0, n_bad = 0, cycles = 0;
    string req = "R1";

    // behavioural reference state
    logic [7:0] m_line, m_feat, m_enh, m_scr, m_dl, m_dh, m_rxt, m_txt, m_rdata, m_v;
    bit         m_alt, m_irq, m_ext, m_dlab, m_set;

    always @(posedge clk) begin
        if (rst) begin
            m_line = 0; m_feat = 0; m_enh = 8'h80; m_scr = 0; m_dl = 0; m_dh = 0;
            m_rxt = 0; m_txt = 0; m_rdata = 0; m_alt = 0; m_irq = 0;
        end else begin
            m_ext  = (m_line == 8'hBF);
            m_dlab = m_line[7];
            if (rd) begin
                m_v = 8'h00;
                case (addr)
                    3'd0: if (m_dlab) m_v = (m_dl == 0 && m_dh == 0) ? 8'h0A : m_dl;
                    3'd1: if (m_dlab) m_v = (m_dl == 0 && m_dh == 0) ? 8'h01 : m_dh;
                    3'd2: if (m_ext) m_v = m_feat;
                    3'd3: m_v = m_line;
                    3'd4: if (m_ext) m_v = m_feat[7] ? 8'(tx_count) : 8'(rx_count);
                    3'd5: m_v = {3'b0, hold_err, 2'b0};
                    3'd7: begin
                        if (m_ext) m_v = m_enh;
                        else if (!m_feat[6]) m_v = m_scr;
                        else begin
                            if (m_enh[1:0] == 2'b01 || (m_enh[1:0] == 2'b10 && m_alt))
                                m_v = 8'(tx_count);
                            else
                                m_v = 8'(rx_count);
                            if (m_enh[1:0] == 2'b10) m_alt = !m_alt;
                        end
                    end
                    default: m_v = 8'h00;
                endcase
                m_rdata = m_v;
            end
            m_set = m_enh[6] ? (rx_push && rx_push_err != 0) : (hold_load && hold_err != 0);
            if (m_set) m_irq = 1;
            else if (rd && addr == 3'd5) m_irq = 0;
            if (wr) begin
                case (addr)
                    3'd3: m_line = wdata;
                    3'd0: if (m_dlab) m_dl = wdata;
                    3'd1: if (m_dlab) m_dh = wdata;
                    3'd2: if (m_ext) m_feat = wdata;
                    3'd4: if (m_ext) begin
                        if (m_feat[7]) m_txt = wdata; else m_rxt = wdata;
                    end
                    3'd7: if (m_ext) begin m_enh = wdata; m_alt = 0; end
                          else m_scr = wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("rdata", 16'(rdata), 16'(m_rdata));
            chk("irq_line R9/R10/R11", 16'(irq_line), 16'(m_irq));
            chk("divisor R7", divisor, {m_dh, m_dl});
            chk("rx_thresh R6", 16'(rx_thresh), 16'(m_rxt));
            chk("tx_thresh R6", 16'(tx_thresh), 16'(m_txt));
            chk("flow_hyst R12", 16'(flow_hyst), 16'(m_feat[1:0]));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input bit r, input bit w, input logic [2:0] a, input logic [7:0] d,
                        input bit push = 0, input logic [2:0] perr = 0,
                        input bit load = 0, input logic [2:0] herr = 0);
        @(negedge clk);
        rd = r; wr = w; addr = a; wdata = d;
        rx_push = push; rx_push_err = perr; hold_load = load; hold_err = herr;
    endtask

    task automatic idle(); step(0, 0, 3'd0, 8'h00); endtask
    task automatic wrr(input logic [2:0] a, input logic [7:0] d); step(0, 1, a, d); endtask
    task automatic rdr(input logic [2:0] a); step(1, 0, a, 8'h00); endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values visible just before release
        chk("R1 rdata", 16'(rdata), 16'h0);
        chk("R1 irq", 16'(irq_line), 16'h0);
        chk("R1 divisor", divisor, 16'h0);
        chk("R1 hyst", 16'(flow_hyst), 16'h0);
        rst = 1'b0;
        req = "R1"; wrr(3'd3, 8'hBF); rdr(3'd7); rdr(3'd2); idle();

        for (int fc = 0; fc < 4; fc++)
            for (int e = 0; e < 2; e++)
                for (int z = 0; z < 2; z++) begin
                    int idx = fc * 4 + e * 2 + z;
                    rx_count = 7'(3 + idx * 3);
                    tx_count = 7'(64 - idx);
                    req = "R7";
                    wrr(3'd3, 8'h80);
                    wrr(3'd0, z ? 8'h00 : 8'h00);
                    wrr(3'd1, z ? 8'h00 : 8'(8'h10 + idx));
                    if (!z && fc[0]) wrr(3'd0, 8'(8'h40 + idx));
                    req = "R2"; wrr(3'd3, 8'hBF);
                    req = "R12"; wrr(3'd2, {fc[1:0], 4'b0, 2'(idx)});
                    req = "R4"; wrr(3'd7, {1'b1, 5'b0, 2'(idx + fc)});
                    req = "R6"; wrr(3'd4, 8'(8'hA0 + idx));
                    if (!e) begin
                        req = "R2"; wrr(3'd3, 8'h83);
                        req = "R3"; wrr(3'd7, 8'(8'h5A ^ idx));
                    end
                    for (int a = 0; a < 8; a++) begin
                        req = (a == 4) ? "R5" : (a == 7) ? "R3" : (a < 2) ? "R7" : "R2";
                        rdr(3'(a));
                        req = "R8"; idle();
                    end
                    req = "R4"; rdr(3'd7); rdr(3'd7); rdr(3'd7); idle();
                end

        // R4: alternating level reads, restart after an enhanced mode rewrite
        req = "R4";
        rx_count = 7'd17; tx_count = 7'd33;
        wrr(3'd3, 8'hBF); wrr(3'd2, 8'h40); wrr(3'd7, 8'h82); wrr(3'd3, 8'h03);
        rdr(3'd7); rdr(3'd7); rdr(3'd7); idle();
        wrr(3'd3, 8'hBF); wrr(3'd7, 8'h82); wrr(3'd3, 8'h03);
        rdr(3'd7); idle(); rdr(3'd7); idle();
        // R2: divisor addresses read zero with DLAB clear
        req = "R2"; rdr(3'd0); rdr(3'd1); rdr(3'd6); idle();

        // R10: delayed mode, push errors ignored, holding load raises
        req = "R10";
        wrr(3'd3, 8'hBF); wrr(3'd7, 8'h80); wrr(3'd3, 8'h03);
        step(0, 0, 3'd0, 8'h00, 1, 3'b010); idle();
        step(0, 0, 3'd0, 8'h00, 0, 3'b000, 1, 3'b000); idle();
        step(0, 0, 3'd0, 8'h00, 0, 3'b000, 1, 3'b100); idle();
        req = "R11"; step(1, 0, 3'd5, 8'h00, 0, 3'b000, 0, 3'b101); idle(); idle();
        // R9: immediate mode, holding load ignored, push raises
        req = "R9";
        wrr(3'd3, 8'hBF); wrr(3'd7, 8'hC0); wrr(3'd3, 8'h03);
        step(0, 0, 3'd0, 8'h00, 0, 3'b000, 1, 3'b111); idle();
        step(0, 0, 3'd0, 8'h00, 1, 3'b001); idle();
        // R11: set and clear in one cycle, set wins; then plain clear
        req = "R11";
        step(1, 0, 3'd5, 8'h00, 1, 3'b100, 0, 3'b010); idle();
        step(1, 0, 3'd5, 8'h00, 0, 3'b000, 0, 3'b001); idle(); idle();
        // R6: transmit threshold path
        req = "R6"; wrr(3'd3, 8'hBF); wrr(3'd2, 8'h80); wrr(3'd4, 8'h3C); rdr(3'd4); idle();

        repeat (3) idle();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule